// File: doc/BRIEF.md
# Synthesizer Test-Output Selector and Divider Chain

This block produces the main output clock of a frequency synthesizer and a separate diagnostic output. A programmable feedback counter (M) and a post-divider with four selectable ratios sit in a divider chain. Normally a VCO-rate clock enable steps this chain. A second, fixed chain divides a reference clock enable by sixteen. All of the logic runs in one system clock domain. Each clock "rate" arrives as a single-cycle enable, so every divider advances only on the cycles where its enable is high.

A 3-bit test code picks what the diagnostic output carries. The choices are:
- the serial shift-register bit;
- a constant high or a constant low;
- the reference divided by sixteen;
- the M counter pulse;
- the main output, or the main output divided by four;
- a bypass mode.

In bypass mode a slow external test-clock enable drives the M counter and the post-divider in place of the VCO enable, and the diagnostic output shows the M counter. A new M or N value takes effect only at that counter's next terminal count, so no shortened pulse can appear on either output.

Top module: `synth_test_mux`

## Requirements
- R1: With test code 3'b000, `test_out` equals `shift_bit` in the same cycle.
- R2: With test code 3'b001, `test_out` is constant 1. With test code 3'b101, it is constant 0.
- R3: With test code 3'b010, `test_out` is the reference divided by 16. It starts at 0 after reset and toggles on every 8th `ref_en` cycle, so the 8th `ref_en` makes it 1.
- R4: With test code 3'b011 (and 3'b110 in bypass), `test_out` is the M counter pulse. For M ≥ 2 it goes high on the first chain enable after reset and then on every M-th chain enable after that. Each time it stays high for exactly one chain-enable interval.
- R5: The post-divider output `fout` starts at 0 after reset and toggles on the first chain enable. After that it toggles every H chain enables, where H is the ratio given by `n_code`: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 1. The output duty cycle is 50%.
- R6: With test code 3'b100, `test_out` equals `fout`. With test code 3'b111, `test_out` is `fout` divided by 4: it starts at 0 and toggles on every second rising edge of `fout`.
- R7: With test code 3'b110 (bypass), `tclk_en` drives the chain and `vco_en` has no effect. The post-divider half-period becomes twice the ratio, so with `n_code` 2'b11, `fout` has a period of 4 test-clock enables.
- R8: With any test code other than 3'b110, `tclk_en` has no effect on `fout` or on the M counter.
- R9: A change of `n_code` takes effect only when the post-divider reaches its next terminal count. The half-period already running completes with the old ratio.
- R10: A change of `m_val` takes effect only when the M counter reaches its next terminal count.
- R11: After reset, `fout`, the M pulse and the divide-by-16 output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_en | input | 1 | VCO-rate step enable |
| ref_en | input | 1 | Reference-rate step enable |
| tclk_en | input | 1 | External test-clock step enable (used in bypass) |
| m_val | input | MW | M counter modulus |
| n_code | input | 2 | Post-divider ratio code |
| t_code | input | 3 | Diagnostic output select |
| shift_bit | input | 1 | Serial shift-register output bit |
| fout | output | 1 | Main divided clock output |
| test_out | output | 1 | Diagnostic output |

## Verification
The bench goes after the reload corner cases first. It changes N and M partway through a count. A design that reloaded at once would shorten the current half-period or pulse and emit a runt, and the bench catches this when the output changes before the old count has run out. The bench also steps the wrong clock source in each mode. A bypass mux wired backwards would keep `fout` running from `vco_en`, and a normal mode that leaked `tclk_en` would count test-clock edges. The remaining checks count edges over a fixed number of enables. These catch a swapped N-code decode, a missing doubling in bypass, a divide-by-16 that toggles one step early, and a divide-by-4 tap that reads the wrong `fout` edge.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  typedef enum logic [2:0] {
    TS_SHIFT  = 3'b000,
    TS_ONE    = 3'b001,
    TS_REF16  = 3'b010,
    TS_MCNT   = 3'b011,
    TS_FOUT   = 3'b100,
    TS_ZERO   = 3'b101,
    TS_BYPASS = 3'b110,
    TS_FOUT4  = 3'b111
  } tsel_e;

  localparam int HALF_W = 5;

  // Post-divider ratio for an N code
  function automatic logic [HALF_W-1:0] n_ratio(input logic [1:0] n);
    case (n)
      2'b00:   return HALF_W'(2);
      2'b01:   return HALF_W'(4);
      2'b10:   return HALF_W'(8);
      default: return HALF_W'(1);
    endcase
  endfunction

  // Half-period in chain enables; bypass doubles it
  function automatic logic [HALF_W-1:0] post_half(input logic [1:0] n, input logic byp);
    logic [HALF_W-1:0] r;
    r = n_ratio(n);
    return byp ? (r << 1) : r;
  endfunction

endpackage

// File: rtl/tsel_mdiv.sv
module tsel_mdiv #(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [MW-1:0] m_val,
  output logic          m_pulse,
  output logic          m_tc
);

  logic [MW-1:0] cnt;

  function automatic logic [MW-1:0] m_reload(input logic [MW-1:0] m);
    return (m == '0) ? '0 : m - MW'(1);
  endfunction

  assign m_tc = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      m_pulse <= 1'b0;
    end else if (en) begin
      m_pulse <= m_tc;
      if (m_tc) cnt <= m_reload(m_val);
      else      cnt <= cnt - MW'(1);
    end
  end

  AST_MPULSE_MIDCOUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |=> !m_pulse); // R4
  AST_MPULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(m_pulse)); // R10
  AST_MPULSE_RISE_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_pulse) |-> $past(cnt) == '0); // R10

endmodule

// File: rtl/tsel_ndiv.sv
module tsel_ndiv
  import tsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              q,
  output logic              q_rise
);

  logic [HALF_W-1:0] cnt;
  logic              tc;

  assign tc     = en && (cnt == '0);
  assign q_rise = tc && !q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (en) begin
      if (tc) begin
        q   <= ~q;
        cnt <= half - HALF_W'(1);
      end else begin
        cnt <= cnt - HALF_W'(1);
      end
    end
  end

  AST_NDIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R5
  AST_NDIV_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> ($past(cnt) == '0)); // R9

endmodule

// File: rtl/tsel_evendiv.sv
module tsel_evendiv #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q
);

  localparam int HALF = RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (en) begin
      if (wrap) begin
        cnt <= '0;
        q   <= ~q;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_EVDIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R3

endmodule

// File: rtl/synth_test_mux.sv
module synth_test_mux
  import tsel_pkg::*;
#(
  parameter int MW      = 9,
  parameter int REF_DIV = 16,
  parameter int OUT_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_en,
  input  logic          ref_en,
  input  logic          tclk_en,
  input  logic [MW-1:0] m_val,
  input  logic [1:0]    n_code,
  input  logic [2:0]    t_code,
  input  logic          shift_bit,
  output logic          fout,
  output logic          test_out
);

  tsel_e             sel;
  logic              bypass;
  logic              chain_en;
  logic [HALF_W-1:0] half;
  logic              m_pulse, m_tc;
  logic              fout_rise;
  logic              ref_tap, fout_tap;

  assign sel      = tsel_e'(t_code);
  assign bypass   = (sel == TS_BYPASS);
  assign chain_en = bypass ? tclk_en : vco_en;
  assign half     = post_half(n_code, bypass);

  tsel_mdiv #(.MW(MW)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .m_val(m_val),
    .m_pulse(m_pulse), .m_tc(m_tc)
  );

  tsel_ndiv u_ndiv (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .half(half),
    .q(fout), .q_rise(fout_rise)
  );

  tsel_evendiv #(.RATIO(REF_DIV)) u_refdiv (
    .clk(clk), .rst_n(rst_n), .en(ref_en), .q(ref_tap)
  );

  tsel_evendiv #(.RATIO(OUT_DIV)) u_outdiv (
    .clk(clk), .rst_n(rst_n), .en(fout_rise), .q(fout_tap)
  );

  always_comb begin
    case (sel)
      TS_SHIFT:  test_out = shift_bit;
      TS_ONE:    test_out = 1'b1;
      TS_REF16:  test_out = ref_tap;
      TS_MCNT:   test_out = m_pulse;
      TS_FOUT:   test_out = fout;
      TS_ZERO:   test_out = 1'b0;
      TS_BYPASS: test_out = m_pulse;
      default:   test_out = fout_tap;
    endcase
  end

  AST_TEST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b001) |-> test_out); // R2
  AST_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b101) |-> !test_out); // R2
  AST_BYPASS_VCO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b110 && !tclk_en) |=> $stable(fout)); // R7
  AST_NORMAL_TCLK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code != 3'b110 && !vco_en) |=> $stable(fout)); // R8
  AST_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b000) |-> (test_out == shift_bit)); // R1

endmodule

// File: tb/synth_test_mux_tb.sv
module synth_test_mux_tb;

  localparam int CLK_P = 10;
  localparam int MW    = 9;
  localparam int NEN   = 48;
  localparam int NVEC  = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vco_en = 1'b0, ref_en = 1'b0, tclk_en = 1'b0;
  logic [MW-1:0] m_val = 9'd5;
  logic [1:0]    n_code = 2'b00;
  logic [2:0]    t_code = 3'b101;
  logic          shift_bit = 1'b0;
  logic          fout, test_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  synth_test_mux #(.MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .ref_en(ref_en), .tclk_en(tclk_en),
    .m_val(m_val), .n_code(n_code), .t_code(t_code), .shift_bit(shift_bit),
    .fout(fout), .test_out(test_out)
  );

  // t[27:25] n[24:23] m[22:14] src[13:12] (0 vco,1 ref,2 tclk) exp_test_rises[11:6] exp_fout_rises[5:0]
  localparam logic [27:0] VECS [NVEC] = '{
    {3'b100, 2'b00, 9'd5,  2'd0, 6'd12, 6'd12}, // R6 R5
    {3'b011, 2'b01, 9'd5,  2'd0, 6'd10, 6'd6 }, // R4 R5
    {3'b011, 2'b10, 9'd12, 2'd0, 6'd4,  6'd3 }, // R4 R5
    {3'b010, 2'b11, 9'd7,  2'd1, 6'd3,  6'd0 }, // R3
    {3'b111, 2'b11, 9'd7,  2'd0, 6'd6,  6'd24}, // R6 R5
    {3'b110, 2'b11, 9'd5,  2'd2, 6'd10, 6'd12}, // R7 R4
    {3'b110, 2'b00, 9'd7,  2'd2, 6'd7,  6'd6 }, // R7
    {3'b110, 2'b11, 9'd5,  2'd0, 6'd0,  6'd0 }, // R7 vco ignored
    {3'b100, 2'b11, 9'd5,  2'd2, 6'd0,  6'd0 }, // R8 tclk ignored
    {3'b001, 2'b00, 9'd5,  2'd0, 6'd0,  6'd12}, // R2
    {3'b101, 2'b00, 9'd5,  2'd0, 6'd0,  6'd12}  // R2
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vco_en = 1'b0; ref_en = 1'b0; tclk_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int src);
    @(negedge clk);
    vco_en  = (src == 0);
    ref_en  = (src == 1);
    tclk_en = (src == 2);
    @(negedge clk);
    vco_en = 1'b0; ref_en = 1'b0; tclk_en = 1'b0;
  endtask

  task automatic run_vec(input logic [27:0] v, input int idx);
    int tr, fr;
    logic pt, pf;
    t_code = v[27:25];
    n_code = v[24:23];
    m_val  = v[22:14];
    do_reset();
    tr = 0; fr = 0;
    pt = test_out; pf = fout;
    for (int i = 0; i < NEN; i++) begin
      step(int'(v[13:12]));
      if (test_out && !pt) tr++;
      if (fout && !pf) fr++;
      pt = test_out; pf = fout;
    end
    chk($sformatf("R4/R6/R7 vec%0d test rises", idx), tr, int'(v[11:6]));
    chk($sformatf("R5/R7/R8 vec%0d fout rises", idx), fr, int'(v[5:0]));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R11 reset state
    t_code = 3'b101; m_val = 9'd5; n_code = 2'b00;
    do_reset();
    @(negedge clk);
    chk("R11 fout after reset", int'(fout), 0);
    t_code = 3'b011; #1;
    chk("R11 M pulse after reset", int'(test_out), 0);
    t_code = 3'b010; #1;
    chk("R11 ref16 after reset", int'(test_out), 0);

    // R1 shift bit passes through
    t_code = 3'b000; shift_bit = 1'b1; #1;
    chk("R1 shift 1", int'(test_out), 1);
    shift_bit = 1'b0; #1;
    chk("R1 shift 0", int'(test_out), 0);
    t_code = 3'b001; #1;
    chk("R2 const high", int'(test_out), 1);

    // Table walk
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

    // R9: N change waits for terminal count
    t_code = 3'b100; n_code = 2'b10; m_val = 9'd5;
    do_reset();
    step(0);
    chk("R9 first toggle", int'(fout), 1);
    n_code = 2'b11;
    for (int i = 2; i <= 8; i++) begin
      step(0);
      chk($sformatf("R9 old ratio held at enable %0d", i), int'(fout), 1);
    end
    step(0);
    chk("R9 toggle at old terminal count", int'(fout), 0);
    step(0);
    chk("R9 new ratio applied", int'(fout), 1);

    // R10: M change waits for terminal count
    t_code = 3'b011; n_code = 2'b00; m_val = 9'd6;
    do_reset();
    step(0);
    chk("R10 first pulse", int'(test_out), 1);
    m_val = 9'd3;
    for (int i = 2; i <= 6; i++) begin
      step(0);
      chk($sformatf("R10 no pulse at enable %0d", i), int'(test_out), 0);
    end
    step(0);
    chk("R10 pulse at old modulus", int'(test_out), 1);
    step(0);
    chk("R10 low after pulse 8", int'(test_out), 0);
    step(0);
    chk("R10 low after pulse 9", int'(test_out), 0);
    step(0);
    chk("R10 pulse at new modulus", int'(test_out), 1);

    // R3 exact edge: 8th ref enable raises the tap
    t_code = 3'b010;
    do_reset();
    for (int i = 1; i <= 7; i++) step(1);
    chk("R3 low after 7 ref enables", int'(test_out), 0);
    step(1);
    chk("R3 high after 8 ref enables", int'(test_out), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule